// File: doc/BRIEF.md
# Banked Peripheral Clock Gate

This block holds one clock-enable bit for each of up to 64 peripherals and drives, for each one, both the registered enable and a gated copy of the system clock. Software turns a peripheral on by writing ones to a set register and turns it off by writing ones to a clear register. Bits written as zero leave their peripherals unchanged, so no read-modify-write is needed. A status register shows the enable bits as they are. The identifiers are split into two 32-bit banks, and each bank has its own set, clear and status locations.

The two lowest identifiers feed logic that must never lose its clock. They are fixed on, they always read as enabled, and writes to their bits do nothing. Each gated clock comes from a latch that is open while the clock is low, followed by an AND gate. An enable change made at a rising edge therefore reaches the gated clock only after the next falling edge, and the gated clock never carries a shortened pulse.

Top module: `periph_clk_gate`

## Requirements
- R1: After reset, identifiers 0 and 1 are enabled and every other identifier is disabled, in both `clkEnOut` and the status registers.
- R2: Identifier i belongs to bank i/32, which is selected by `addr[2]`, and it sits at bit i%32 of that bank's words. `addr[1:0]` selects the function: 0 is set, 1 is clear, 2 is status, and 3 is unused.
- R3: A write to the set location enables every identifier whose data bit is 1. The enable is visible on `clkEnOut` after the write's clock edge. Bits written as 0 do not change.
- R4: A write to the clear location disables every identifier whose data bit is 1. Bits written as 0 do not change.
- R5: A read of the status location returns, on `rdData` in the cycle after `rdEn`, the current enable of every identifier in that bank. `rdData` is zero in any cycle that does not follow a status read.
- R6: Identifiers 0 and 1 cannot be disabled: writing ones to their clear bits leaves them enabled.
- R7: Reads of the set, clear and unused locations return zero.
- R8: `gatedClk[i]` follows `clk` while identifier i is enabled and stays low while it is disabled. A change takes effect in the high phase that follows the next falling edge. The high phase in which the write lands keeps the old state.
- R9: Without `wrEn` the enables never change, whatever `addr` and `wrData` hold, and status reads leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, also the source of every gated clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| addr | input | 3 | Bank (bit 2) and function (bits 1:0) |
| wrData | input | 32 | Write data, one bit per identifier in the bank |
| rdData | output | 32 | Registered read data |
| clkEnOut | output | 64 | Registered enable for each identifier |
| gatedClk | output | 64 | Glitch-free gated clock for each identifier |

## Verification
The bench sweeps every identifier through a set and a clear, one at a time. After each write it compares the whole 64-bit enable vector and both status words against an arithmetic model. A bank decode error would therefore show up as a bit moving in the wrong word, and an off-by-one in the bit position would show up as a neighbouring identifier changing. Pattern writes that mix zeros and ones check that zero bits are left alone and that the two fixed-on identifiers survive clear writes. A design that drops the protection on those two identifiers would switch them off.

The bench also probes the gated clock in the high phase in which a write lands and in the high phase after it. A gate that lacked the falling-edge latch would change state in the middle of the first high phase and cut that pulse short.

// File: rtl/pcg_pkg.sv
package pcg_pkg;
  localparam int PCG_WORD   = 32;
  localparam int PCG_BANK_W = 1;
  localparam int PCG_FUNC_W = 2;
  localparam int PCG_ADDR_W = PCG_BANK_W + PCG_FUNC_W;

  localparam logic [PCG_FUNC_W-1:0] FN_SET  = 2'd0;
  localparam logic [PCG_FUNC_W-1:0] FN_CLR  = 2'd1;
  localparam logic [PCG_FUNC_W-1:0] FN_STAT = 2'd2;

  typedef struct packed {
    logic                  wrSet;
    logic                  wrClr;
    logic                  rdStat;
    logic [PCG_BANK_W-1:0] bank;
  } pcgCmd_t;
endpackage

// File: rtl/pcg_ctrl.sv
module pcg_ctrl
  import pcg_pkg::*;
#(
  parameter int BANKS = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic                  rdEn,
  input  logic [PCG_ADDR_W-1:0] addr,
  output pcgCmd_t               cmd
);
  logic [PCG_FUNC_W-1:0] func;
  logic [PCG_BANK_W-1:0] bankSel;
  logic                  bankOk;

  assign func    = addr[PCG_FUNC_W-1:0];
  assign bankSel = addr[PCG_FUNC_W +: PCG_BANK_W];
  assign bankOk  = (int'(bankSel) < BANKS);

  always_comb begin
    cmd        = '0;
    cmd.bank   = bankSel;
    cmd.wrSet  = wrEn && bankOk && (func == FN_SET);
    cmd.wrClr  = wrEn && bankOk && (func == FN_CLR);
    cmd.rdStat = rdEn && bankOk && (func == FN_STAT);
  end

  // R9
  no_write_without_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |-> !(cmd.wrSet || cmd.wrClr));
endmodule

// File: rtl/pcg_datapath.sv
module pcg_datapath
  import pcg_pkg::*;
#(
  parameter int NUM_IDS   = 64,
  parameter int ALWAYS_ON = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  pcgCmd_t             cmd,
  input  logic [PCG_WORD-1:0] wrData,
  output logic [PCG_WORD-1:0] rdData,
  output logic [NUM_IDS-1:0]  enReg
);
  localparam int W     = PCG_WORD;
  localparam int BANKS = (NUM_IDS + W - 1) / W;
  localparam int PAD   = BANKS * W;
  localparam logic [NUM_IDS-1:0] ON_MASK = NUM_IDS'((64'd1 << ALWAYS_ON) - 64'd1);
  localparam logic [PAD-1:0]     ON_PAD  = PAD'(ON_MASK);

  logic [NUM_IDS-1:0] enNext;
  logic [PAD-1:0]     enPad;

  for (genvar i = 0; i < PAD; i++) begin : g_pad
    if (i < NUM_IDS) begin : g_live
      assign enPad[i] = enReg[i];
    end else begin : g_dead
      assign enPad[i] = 1'b0;
    end
  end

  for (genvar i = 0; i < NUM_IDS; i++) begin : g_bit
    localparam int B = i / W;
    localparam int P = i % W;
    if (i < ALWAYS_ON) begin : g_fixed
      assign enNext[i] = 1'b1;
    end else begin : g_ctl
      logic hit;
      assign hit = (cmd.bank == PCG_BANK_W'(B)) && wrData[P];
      assign enNext[i] = (cmd.wrClr && hit) ? 1'b0 :
                         (cmd.wrSet && hit) ? 1'b1 : enReg[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) enReg <= ON_MASK;
    else       enReg <= enNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN)           rdData <= '0;
    else if (cmd.rdStat) rdData <= enPad[int'(cmd.bank)*W +: W];
    else                 rdData <= '0;
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_chk
    // R3
    set_takes_chk: assert property (@(posedge clk) disable iff (!rstN)
      (cmd.wrSet && cmd.bank == PCG_BANK_W'(b)) |=>
        ((enPad[b*W +: W] & $past(wrData)) == $past(wrData)));
    // R4
    clear_takes_chk: assert property (@(posedge clk) disable iff (!rstN)
      (cmd.wrClr && cmd.bank == PCG_BANK_W'(b)) |=>
        ((enPad[b*W +: W] & $past(wrData) & ~ON_PAD[b*W +: W]) == '0));
  end

  // R6
  fixed_on_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmd.wrClr |=> (&enReg[ALWAYS_ON-1:0]));
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(cmd.wrSet || cmd.wrClr) |=> $stable(enReg));
  // R7
  idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cmd.rdStat |=> (rdData == '0));
endmodule

// File: rtl/pcg_clk_gate.sv
module pcg_clk_gate (
  input  logic clk,
  input  logic en,
  output logic gclk
);
  logic enLat;

  always_latch begin
    if (!clk) enLat = en;
  end

  assign gclk = clk & enLat;
endmodule

// File: rtl/periph_clk_gate.sv
module periph_clk_gate
  import pcg_pkg::*;
#(
  parameter int NUM_IDS   = 64,
  parameter int ALWAYS_ON = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic                  rdEn,
  input  logic [PCG_ADDR_W-1:0] addr,
  input  logic [PCG_WORD-1:0]   wrData,
  output logic [PCG_WORD-1:0]   rdData,
  output logic [NUM_IDS-1:0]    clkEnOut,
  output logic [NUM_IDS-1:0]    gatedClk
);
  localparam int BANKS = (NUM_IDS + PCG_WORD - 1) / PCG_WORD;

  pcgCmd_t cmd;

  pcg_ctrl #(.BANKS(BANKS)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .cmd(cmd)
  );

  pcg_datapath #(.NUM_IDS(NUM_IDS), .ALWAYS_ON(ALWAYS_ON)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .wrData(wrData),
    .rdData(rdData), .enReg(clkEnOut)
  );

  for (genvar i = 0; i < NUM_IDS; i++) begin : g_gate
    pcg_clk_gate u_gate (.clk(clk), .en(clkEnOut[i]), .gclk(gatedClk[i]));
  end
endmodule

// File: tb/periph_clk_gate_tb.sv
module periph_clk_gate_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [63:0] clkEnOut;
  logic [63:0] gatedClk;

  int total = 0;
  int bad = 0;
  bit doneFlag = 1'b0;
  logic [63:0] model;

  always #(CLK_PERIOD/2) clk = ~clk;

  periph_clk_gate u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .clkEnOut(clkEnOut), .gatedClk(gatedClk)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
    if (a[1:0] == 2'd0) begin
      if (a[2]) model[63:32] = model[63:32] | d;
      else      model[31:0]  = model[31:0]  | d;
    end else if (a[1:0] == 2'd1) begin
      if (a[2]) model[63:32] = model[63:32] & ~d;
      else      model[31:0]  = model[31:0]  & ~d;
    end
    model[1:0] = 2'b11;
  endtask

  task automatic busRead(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
  endtask

  task automatic checkStatus(input string req);
    logic [31:0] w;
    busRead(3'b010, w); check(req, {32'd0, w}, {32'd0, model[31:0]});
    busRead(3'b110, w); check(req, {32'd0, w}, {32'd0, model[63:32]});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!doneFlag) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] w;
    model = 64'h3;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", clkEnOut, 64'h3);
    checkStatus("R1");

    // R2 R3 R4 R6: sweep every identifier through set and clear
    for (int id = 0; id < 64; id++) begin
      busWrite({id[5] == 1'b1, 2'b00}, 32'd1 << (id % 32));
      check("R3", clkEnOut, model);
      check("R2", {63'd0, clkEnOut[id]}, 64'd1);
      checkStatus("R5");
      busWrite({id[5] == 1'b1, 2'b01}, 32'd1 << (id % 32));
      check(id < 2 ? "R6" : "R4", clkEnOut, model);
    end

    // R3 R4: patterns with zero bits left alone
    busWrite(3'b000, 32'hF0F0_1234);
    busWrite(3'b100, 32'h8000_0001);
    check("R3", clkEnOut, model);
    busWrite(3'b001, 32'hFFFF_0000);
    check("R4", clkEnOut, model);
    busWrite(3'b101, 32'h0000_0001);
    check("R4", clkEnOut, model);
    busWrite(3'b001, 32'hFFFF_FFFF);
    check("R6", clkEnOut[1:0], 64'h3);
    busWrite(3'b000, 32'hFFFF_FFFF);
    busWrite(3'b100, 32'h5555_AAAA);
    checkStatus("R5");

    // R7 other locations read zero
    busRead(3'b000, w); check("R7", {32'd0, w}, 64'd0);
    busRead(3'b001, w); check("R7", {32'd0, w}, 64'd0);
    busRead(3'b011, w); check("R7", {32'd0, w}, 64'd0);
    busRead(3'b100, w); check("R7", {32'd0, w}, 64'd0);
    busRead(3'b111, w); check("R7", {32'd0, w}, 64'd0);
    // R5 rdData returns to zero after a status read
    busRead(3'b110, w);
    @(negedge clk);
    check("R5", {32'd0, rdData}, 64'd0);

    // R9 bus activity without wrEn
    @(negedge clk);
    addr = 3'b001; wrData = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    addr = 3'b100;
    repeat (2) @(negedge clk);
    wrData = '0;
    check("R9", clkEnOut, model);
    checkStatus("R9");

    // R8 gated clock timing, identifier 5 off then on
    busWrite(3'b001, 32'h0000_0020);
    @(posedge clk); #1;
    check("R8", {63'd0, gatedClk[5]}, 64'd0);
    @(negedge clk);
    wrEn = 1'b1; addr = 3'b000; wrData = 32'h0000_0020;
    @(posedge clk); #1;
    check("R8", {63'd0, gatedClk[5]}, 64'd0);
    @(negedge clk);
    wrEn = 1'b0; wrData = '0; model[5] = 1'b1;
    check("R8", {63'd0, gatedClk[5]}, 64'd0);
    @(posedge clk); #1;
    check("R8", {63'd0, gatedClk[5]}, 64'd1);
    // R8 identifier 40 on then off in the same way
    busWrite(3'b100, 32'h0000_0100);
    @(negedge clk);
    wrEn = 1'b1; addr = 3'b101; wrData = 32'h0000_0100;
    @(posedge clk); #1;
    check("R8", {63'd0, gatedClk[40]}, 64'd1);
    @(negedge clk);
    wrEn = 1'b0; wrData = '0; model[40] = 1'b0;
    @(posedge clk); #1;
    check("R8", {63'd0, gatedClk[40]}, 64'd0);
    check("R8", {63'd0, gatedClk[0]}, 64'd1);
    @(negedge clk);
    check("R8", {63'd0, gatedClk[0]}, 64'd0);
    check("R3", clkEnOut, model);

    doneFlag = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule